// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM device and the controller's own pad DLL out of reset without any software involvement. Once reset is released it counts the required settle intervals in controller clock cycles. It sets up the pad DLL by holding it in reset, applying a frequency select value and then letting it run. It then raises clock enable and issues the mode programming commands in a fixed order. When the sequence is complete it raises `initDone`. All interval lengths come from the clock frequency parameter and are rounded up, so the minimum times are always met.

Two start-up flavours exist, and `backupMode` picks between them. It is sampled in the first cycle after reset. In a cold start the sequencer waits for supply and clock settling and for the DLL to lock. In a warm restart, where the memory kept its contents in a powered backup state, both long waits are skipped. The drive strength, termination and OCD settings are captured once in that same first cycle. The captured values drive the controller's pad outputs and also the fields of the EMRS(1) command, so the two always agree.

Top module: `ddr2_powerup_seq`

## Requirements
- R1: While `rst` is high the outputs are `cke`=0, `padDllRun`=0, `padFreqSel`=0, `initDone`=0 and the command pins are NOP. NOP is `{csN,rasN,casN,weN}`=4'b0111, with `ba` and `addr` equal to zero.
- R2: In a cold start (`backupMode`=0), `padFreqSel` keeps its reset value and `padDllRun` stays 0 for at least ceil(PWR_NS*CLK_MHZ/1000) cycles after reset is released.
- R3: The pad DLL is started in this order. First `padFreqSel` takes the value FREQ_SEL while `padDllRun` is still 0, and only after that does `padDllRun` rise. `padFreqSel` does not change while `padDllRun` is high.
- R4: In a cold start, `cke` rises no sooner than ceil(DLL_NS*CLK_MHZ/1000) cycles after `padDllRun` rises.
- R5: In a warm start (`backupMode`=1), both long waits are skipped and `cke` rises within SETUP_CYC+4 cycles of reset release. The R3 ordering still holds.
- R6: The first command appears no sooner than ceil(CKE_NS*CLK_MHZ/1000) cycles after `cke` rises, and `cke` stays high from then on.
- R7: Exactly four commands are issued, in this order. The first is precharge-all (4'b0010 with `addr[10]`=1). Then come EMRS(2) with `ba`=2, EMRS(3) with `ba`=3 and EMRS(1) with `ba`=1. Each EMRS is the mode-register code 4'b0000.
- R8: Each command is driven for exactly one cycle. Between consecutive commands at least GAP_CYC NOP cycles appear.
- R9: EMRS(1) carries `addr[1]`=drive-half, `{addr[6],addr[2]}`=termination select and `addr[9:7]`=OCD setting. All other address bits are 0. The pad outputs `padDrvHalf`, `padOdtSel` and `padOcdSel` carry the same captured values.
- R10: `initDone` rises no sooner than GUARD_CYC cycles after EMRS(1). It then stays high together with `cke` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| backupMode | input | 1 | 1 = warm restart from powered backup |
| drvHalf | input | 1 | Reduced drive strength select |
| odtSel | input | 2 | Termination select |
| ocdSel | input | 3 | OCD setting |
| cke | output | 1 | Memory clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Address bus |
| padDllRun | output | 1 | Pad DLL reset release (0 = held in reset) |
| padFreqSel | output | FREQ_W | Pad DLL frequency select |
| padDrvHalf | output | 1 | Pad drive strength applied |
| padOdtSel | output | 2 | Pad termination applied |
| padOcdSel | output | 3 | Pad OCD setting applied |
| initDone | output | 1 | Sequence complete, sticky until reset |

## Verification
The assertions assume that `rst` is synchronous and held for at least one clock edge. They also assume that the settings inputs are stable in the first cycle after reset, when they are captured. The bench changes `backupMode` and the settings only while reset is high and holds them through the whole sequence. The sequence is started again from reset for each table entry. It is also interrupted once in the middle of the cold-start wait.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_EMRS1,
    CMD_EMRS2,
    CMD_EMRS3
  } cmd_e;

  typedef struct packed {
    logic capture;
    logic setFreq;
    logic dllRelease;
    logic ckeOn;
    logic issue;
    cmd_e cmd;
    logic done;
  } strobe_t;

endpackage

// File: rtl/init_ctrl.sv
module init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int PWR_CYC   = 10000,
  parameter int DLL_CYC   = 10000,
  parameter int CKE_CYC   = 40,
  parameter int SETUP_CYC = 2,
  parameter int GAP_CYC   = 4,
  parameter int GUARD_CYC = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    backupMode,
  output strobe_t stb
);

  localparam int MAX_A   = (PWR_CYC > DLL_CYC) ? PWR_CYC : DLL_CYC;
  localparam int MAX_B   = (CKE_CYC > GUARD_CYC) ? CKE_CYC : GUARD_CYC;
  localparam int MAX_C   = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  typedef enum logic [3:0] {
    ST_START, ST_PWR, ST_DLLSET, ST_DLLWAIT, ST_CKE,
    ST_CMD, ST_GAP, ST_GUARD, ST_DONE
  } state_e;

  state_e           state, stateNx;
  logic [CNT_W-1:0] timer, timerNx;
  logic [1:0]       cmdIdx, idxNx;
  logic             warm, warmNx;

  function automatic cmd_e idxToCmd(input logic [1:0] idx);
    case (idx)
      2'd0:    return CMD_PALL;
      2'd1:    return CMD_EMRS2;
      2'd2:    return CMD_EMRS3;
      default: return CMD_EMRS1;
    endcase
  endfunction

  always_comb begin
    stateNx = state;
    timerNx = timer;
    idxNx   = cmdIdx;
    warmNx  = warm;
    stb     = '0;
    stb.cmd = CMD_NOP;
    case (state)
      ST_START: begin
        stb.capture = 1'b1;
        warmNx      = backupMode;
        if (backupMode) begin
          stateNx     = ST_DLLSET;
          timerNx     = CNT_W'(SETUP_CYC - 1);
          stb.setFreq = 1'b1;
        end else begin
          stateNx = ST_PWR;
          timerNx = CNT_W'(PWR_CYC - 1);
        end
      end
      ST_PWR: begin
        if (timer == '0) begin
          stateNx     = ST_DLLSET;
          timerNx     = CNT_W'(SETUP_CYC - 1);
          stb.setFreq = 1'b1;
        end else timerNx = timer - 1'b1;
      end
      ST_DLLSET: begin
        if (timer == '0) begin
          stb.dllRelease = 1'b1;
          if (warm) begin
            stateNx   = ST_CKE;
            timerNx   = CNT_W'(CKE_CYC - 1);
            stb.ckeOn = 1'b1;
          end else begin
            stateNx = ST_DLLWAIT;
            timerNx = CNT_W'(DLL_CYC - 1);
          end
        end else timerNx = timer - 1'b1;
      end
      ST_DLLWAIT: begin
        if (timer == '0) begin
          stateNx   = ST_CKE;
          timerNx   = CNT_W'(CKE_CYC - 1);
          stb.ckeOn = 1'b1;
        end else timerNx = timer - 1'b1;
      end
      ST_CKE: begin
        if (timer == '0) stateNx = ST_CMD;
        else timerNx = timer - 1'b1;
      end
      ST_CMD: begin
        stb.issue = 1'b1;
        stb.cmd   = idxToCmd(cmdIdx);
        if (cmdIdx == 2'd3) begin
          stateNx = ST_GUARD;
          timerNx = CNT_W'(GUARD_CYC - 1);
        end else begin
          stateNx = ST_GAP;
          timerNx = CNT_W'(GAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (timer == '0) begin
          stateNx = ST_CMD;
          idxNx   = cmdIdx + 1'b1;
        end else timerNx = timer - 1'b1;
      end
      ST_GUARD: begin
        if (timer == '0) begin
          stateNx  = ST_DONE;
          stb.done = 1'b1;
        end else timerNx = timer - 1'b1;
      end
      default: stateNx = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_START;
      timer  <= '0;
      cmdIdx <= '0;
      warm   <= 1'b0;
    end else begin
      state  <= stateNx;
      timer  <= timerNx;
      cmdIdx <= idxNx;
      warm   <= warmNx;
    end
  end

  // R7: the guard interval is only entered after the last of the four commands
  a_r7_last_before_guard: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GUARD) |-> (cmdIdx == 2'd3));

  // R5: a warm restart never visits the long wait states
  a_r5_warm_skips: assert property (@(posedge clk) disable iff (rst)
    (warm && state != ST_START) |-> (state != ST_PWR && state != ST_DLLWAIT));

endmodule

// File: rtl/init_dpath.sv
module init_dpath
  import ddr2_init_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int BA_W     = 3,
  parameter int FREQ_W   = 2,
  parameter int FREQ_SEL = 1,
  parameter int CKE_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic              drvHalf,
  input  logic [1:0]        odtSel,
  input  logic [2:0]        ocdSel,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ROW_W-1:0]  addr,
  output logic              padDllRun,
  output logic [FREQ_W-1:0] padFreqSel,
  output logic              padDrvHalf,
  output logic [1:0]        padOdtSel,
  output logic [2:0]        padOcdSel,
  output logic              initDone
);

  localparam logic [FREQ_W-1:0] FREQ_VAL = FREQ_W'(FREQ_SEL);
  localparam int AGE_W = $clog2(CKE_CYC + 1);

  logic [ROW_W-1:0] emrs1Addr;
  logic [ROW_W-1:0] pallAddr;

  always_comb begin
    emrs1Addr    = '0;
    emrs1Addr[1] = padDrvHalf;
    emrs1Addr[2] = padOdtSel[0];
    emrs1Addr[6] = padOdtSel[1];
    emrs1Addr[9:7] = padOcdSel;
    pallAddr     = '0;
    pallAddr[10] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke        <= 1'b0;
      csN        <= 1'b0;
      rasN       <= 1'b1;
      casN       <= 1'b1;
      weN        <= 1'b1;
      ba         <= '0;
      addr       <= '0;
      padDllRun  <= 1'b0;
      padFreqSel <= '0;
      padDrvHalf <= 1'b0;
      padOdtSel  <= '0;
      padOcdSel  <= '0;
      initDone   <= 1'b0;
    end else begin
      if (stb.capture) begin
        padDrvHalf <= drvHalf;
        padOdtSel  <= odtSel;
        padOcdSel  <= ocdSel;
      end
      if (stb.setFreq) begin
        padDllRun  <= 1'b0;
        padFreqSel <= FREQ_VAL;
      end
      if (stb.dllRelease) padDllRun <= 1'b1;
      if (stb.ckeOn) cke <= 1'b1;
      if (stb.done) initDone <= 1'b1;
      csN  <= 1'b0;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      ba   <= '0;
      addr <= '0;
      if (stb.issue) begin
        case (stb.cmd)
          CMD_PALL: begin
            rasN <= 1'b0; weN <= 1'b0;
            addr <= pallAddr;
          end
          CMD_EMRS1: begin
            rasN <= 1'b0; casN <= 1'b0; weN <= 1'b0;
            ba   <= BA_W'(1);
            addr <= emrs1Addr;
          end
          CMD_EMRS2: begin
            rasN <= 1'b0; casN <= 1'b0; weN <= 1'b0;
            ba   <= BA_W'(2);
          end
          CMD_EMRS3: begin
            rasN <= 1'b0; casN <= 1'b0; weN <= 1'b0;
            ba   <= BA_W'(3);
          end
          default: ;
        endcase
      end
    end
  end

  // Cycles that clock enable has been high, saturating; used by the R6 check
  logic [AGE_W-1:0] ckeAge;
  always_ff @(posedge clk) begin
    if (rst) ckeAge <= '0;
    else if (cke && ckeAge < AGE_W'(CKE_CYC)) ckeAge <= ckeAge + 1'b1;
  end

  a_r8_one_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
    !(rasN && casN && weN) |=> (rasN && casN && weN));

  a_r6_cke_settled: assert property (@(posedge clk) disable iff (rst)
    !(rasN && casN && weN) |-> (cke && ckeAge >= AGE_W'(CKE_CYC)));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    initDone |=> (initDone && cke));

  a_r6_cke_held: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  a_r3_freq_before_run: assert property (@(posedge clk) disable iff (rst)
    $rose(padDllRun) |-> (padFreqSel == FREQ_VAL));

  a_r3_freq_held: assert property (@(posedge clk) disable iff (rst)
    padDllRun |=> $stable(padFreqSel));

endmodule

// File: rtl/ddr2_powerup_seq.sv
module ddr2_powerup_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PWR_NS    = 100000,
  parameter int DLL_NS    = 100000,
  parameter int CKE_NS    = 400,
  parameter int SETUP_CYC = 2,
  parameter int GAP_CYC   = 4,
  parameter int GUARD_CYC = 16,
  parameter int ROW_W     = 14,
  parameter int BA_W      = 3,
  parameter int FREQ_W    = 2,
  parameter int FREQ_SEL  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              backupMode,
  input  logic              drvHalf,
  input  logic [1:0]        odtSel,
  input  logic [2:0]        ocdSel,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ROW_W-1:0]  addr,
  output logic              padDllRun,
  output logic [FREQ_W-1:0] padFreqSel,
  output logic              padDrvHalf,
  output logic [1:0]        padOdtSel,
  output logic [2:0]        padOcdSel,
  output logic              initDone
);

  // Round every interval up so the minimum time is always met
  localparam int PWR_CYC = (PWR_NS * CLK_MHZ + 999) / 1000;
  localparam int DLL_CYC = (DLL_NS * CLK_MHZ + 999) / 1000;
  localparam int CKE_CYC = (CKE_NS * CLK_MHZ + 999) / 1000;

  strobe_t stb;

  init_ctrl #(
    .PWR_CYC(PWR_CYC), .DLL_CYC(DLL_CYC), .CKE_CYC(CKE_CYC),
    .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC), .GUARD_CYC(GUARD_CYC)
  ) i_ctrl (
    .clk(clk), .rst(rst), .backupMode(backupMode), .stb(stb)
  );

  init_dpath #(
    .ROW_W(ROW_W), .BA_W(BA_W), .FREQ_W(FREQ_W),
    .FREQ_SEL(FREQ_SEL), .CKE_CYC(CKE_CYC)
  ) i_dpath (
    .clk(clk), .rst(rst), .stb(stb),
    .drvHalf(drvHalf), .odtSel(odtSel), .ocdSel(ocdSel),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr),
    .padDllRun(padDllRun), .padFreqSel(padFreqSel),
    .padDrvHalf(padDrvHalf), .padOdtSel(padOdtSel), .padOcdSel(padOcdSel),
    .initDone(initDone)
  );

endmodule

// File: tb/test_ddr2_powerup_seq.sv
module test_ddr2_powerup_seq;

  localparam int PWR = 10000;  // 100 us at 100 MHz
  localparam int DLL = 10000;
  localparam int CKE = 40;     // 400 ns
  localparam int SETUP = 2;
  localparam int GAP = 4;
  localparam int GUARD = 16;
  localparam int FSEL = 1;

  // {backupMode, drvHalf, odtSel[1:0], ocdSel[2:0]}
  localparam logic [6:0] VEC [4] = '{
    7'b0_1_01_000,
    7'b1_0_10_111,
    7'b1_1_11_101,
    7'b0_0_00_011
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic backupMode = 1'b0, drvHalf = 1'b0;
  logic [1:0] odtSel = '0;
  logic [2:0] ocdSel = '0;
  logic cke, csN, rasN, casN, weN, padDllRun, padDrvHalf, initDone;
  logic [2:0] ba, padOcdSel;
  logic [13:0] addr;
  logic [1:0] padFreqSel, padOdtSel;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_powerup_seq i_ddr2_powerup_seq (
    .clk(clk), .rst(rst), .backupMode(backupMode), .drvHalf(drvHalf),
    .odtSel(odtSel), .ocdSel(ocdSel), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .padDllRun(padDllRun),
    .padFreqSel(padFreqSel), .padDrvHalf(padDrvHalf), .padOdtSel(padOdtSel),
    .padOcdSel(padOcdSel), .initDone(initDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {csN, rasN, casN, weN};
  endfunction

  task automatic checkResetState();
    chk(cke == 0 && padDllRun == 0 && padFreqSel == 0 && initDone == 0, "R1 ctrl",
        {cke, padDllRun, padFreqSel, initDone}, 0);
    chk(pins() == 4'b0111 && ba == 0 && addr == 0, "R1 nop", pins(), 7);
  endtask

  task automatic runSeq(input logic [6:0] v);
    int rel, tFreq, tDll, tCke, tDone, n;
    int tCmd[8];
    int code[8];
    int bav[8];
    logic [13:0] av[8];
    logic prevDll, prevCke, prevDone, prevCmd;
    logic [13:0] e1;
    @(negedge clk);
    rst = 1'b1;
    {backupMode, drvHalf, odtSel, ocdSel} = v;
    repeat (3) @(negedge clk);
    checkResetState();
    rst = 1'b0;
    rel = cyc;
    tFreq = -1; tDll = -1; tCke = -1; tDone = -1; n = 0;
    prevDll = 0; prevCke = 0; prevDone = 0; prevCmd = 0;
    for (int k = 0; k < 25000 && tDone < 0; k++) begin
      @(negedge clk);
      if (tFreq < 0 && padFreqSel != 0) begin
        tFreq = cyc;
        chk(padDllRun == 0, "R3 freq set while DLL held", padDllRun, 0);
      end
      if (padDllRun && !prevDll) begin
        tDll = cyc;
        chk(padFreqSel == 2'(FSEL), "R3 freq at release", padFreqSel, FSEL);
      end
      if (cke && !prevCke) tCke = cyc;
      if (pins() != 4'b0111) begin
        chk(!prevCmd, "R8 single cycle command", 1, 0);
        if (n < 8) begin
          tCmd[n] = cyc; code[n] = pins(); bav[n] = ba; av[n] = addr;
        end
        n++;
        prevCmd = 1;
      end else prevCmd = 0;
      if (initDone && !prevDone) tDone = cyc;
      prevDll = padDllRun; prevCke = cke; prevDone = initDone;
    end
    chk(tFreq >= 0 && tDll > tFreq, "R3 order freq then release", tDll, tFreq + 1);
    if (!v[6]) begin
      chk(tFreq - rel >= PWR, "R2 cold wait before DLL", tFreq - rel, PWR);
      chk(tCke - tDll >= DLL, "R4 DLL settle", tCke - tDll, DLL);
    end else begin
      chk(tCke >= 0 && tCke - rel <= SETUP + 4, "R5 warm start cke", tCke - rel, SETUP + 4);
    end
    chk(n == 4, "R7 command count", n, 4);
    if (n == 4) begin
      chk(tCmd[0] - tCke >= CKE, "R6 cke to first command", tCmd[0] - tCke, CKE);
      chk(code[0] == 4'b0010 && av[0][10], "R7 precharge-all", code[0], 2);
      chk(code[1] == 0 && bav[1] == 2, "R7 EMRS2", bav[1], 2);
      chk(code[2] == 0 && bav[2] == 3, "R7 EMRS3", bav[2], 3);
      chk(code[3] == 0 && bav[3] == 1, "R7 EMRS1", bav[3], 1);
      for (int i = 0; i < 3; i++)
        chk(tCmd[i+1] - tCmd[i] - 1 >= GAP, "R8 NOP gap", tCmd[i+1] - tCmd[i] - 1, GAP);
      e1 = '0;
      e1[1] = v[5]; e1[6] = v[4]; e1[2] = v[3]; e1[9:7] = v[2:0];
      chk(av[3] == e1, "R9 EMRS1 fields", av[3], e1);
      chk(tDone - tCmd[3] >= GUARD, "R10 guard", tDone - tCmd[3], GUARD);
    end
    chk({padDrvHalf, padOdtSel, padOcdSel} == v[5:0], "R9 pad settings",
        {padDrvHalf, padOdtSel, padOcdSel}, v[5:0]);
    repeat (40) @(negedge clk);
    chk(initDone && cke && pins() == 4'b0111, "R10 done held", {initDone, cke}, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checkResetState();
    for (int v = 0; v < 4; v++) runSeq(VEC[v]);

    // Directed: reset in the middle of a cold-start wait
    @(negedge clk);
    rst = 1'b1;
    {backupMode, drvHalf, odtSel, ocdSel} = 7'b0_1_11_110;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (500) @(negedge clk);
    chk(!padDllRun && padFreqSel == 0 && !cke, "R2 still waiting", padDllRun, 0);
    rst = 1'b1;
    @(negedge clk);
    checkResetState();
    chk({padDrvHalf, padOdtSel, padOcdSel} == 0, "R1 pads cleared",
        {padDrvHalf, padOdtSel, padOcdSel}, 0);

    // Directed: a warm start right after an interrupted cold start
    runSeq(7'b1_0_01_001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule